// File: doc/BRIEF.md
# Programmable Prioritised Interrupt Controller

This block arbitrates eight interrupt request lines for a processor. Request pulses from an upstream capture block set bits in a pending register. A small two-port register bus sets up the controller and then controls it at run time. The controller holds a mask, an in-service register and a rotatable priority origin. It raises a single interrupt line whenever the strongest unmasked pending request outranks everything currently being serviced.

Software brings the controller up with an initialisation sequence. It writes a start word on port 0, then writes the vector base, a word that is ignored and, when asked for, a mode word on port 1. After that, port-1 writes load the mask. Port-0 writes act as run-time commands: end-of-interrupt (general or for a named line, either of which may also rotate), setting the priority origin, choosing the readback register, and arming a one-shot poll. The processor acknowledges an interrupt with a strobe. The controller presents the winning line and a vector, which is the base plus the line index.

Top module: `prio_intc`

## Requirements
- R1: Priority p (0 is highest) belongs to line (p + origin) mod 8, where origin is a 3-bit register that is 0 after reset. `line_o` gives the winning line among pending requests whose mask bit (bit n masks line n) is clear.
- R2: `irq_o` is high only when the best unmasked pending priority is strictly lower in number than the best in-service priority (an empty set counts as 8). A request of equal or weaker priority than the active service level stays unsignalled.
- R3: Reset, or a port-0 write with bit 4 set, clears pending, mask, in-service, origin, base, readback select, poll and all mode flags, and drops `irq_o`. An initialisation write also records its bit 0 as "mode word follows".
- R4: After an initialisation write, port-1 writes take, in order: the vector base (written value with bits 2:0 forced to 0), a word that is ignored, then the mode word only if requested. Later port-1 writes load the mask, and port-1 reads return the mask.
- R5: A port-0 write with bit 4 clear and bit 3 set is read control. When bit 1 is set, bit 0 selects the port-0 readback: 1 gives the in-service register, 0 gives pending. When bit 2 is set, poll is armed.
- R6: Other port-0 writes decode bits 7:5 as follows. Codes 0 and 4 set rotate-on-auto-EOI to bit 7. Code 1 clears the highest-priority in-service bit, and code 5 also sets origin to that line + 1. Code 3 clears in-service bit (value & 7). Code 6 sets origin to (value + 1) & 7. Code 7 clears in-service bit (value & 7) and sets origin to that line + 1. Code 2 does nothing.
- R7: An `ack_i` pulse while `irq_o` is high clears the winner's pending bit. Without auto-EOI it sets the winner's in-service bit. With auto-EOI the in-service bit is left alone, and origin becomes winner + 1 if rotate-on-auto-EOI is set.
- R8: A read on either port while poll is armed returns the winning line and clears that line's pending and in-service bits, or returns 7 with no change if nothing would interrupt. Poll disarms after that one read.
- R9: `vector_o` equals the vector base plus `line_o`.
- R10: The mode word sets special nesting from bit 4 and auto-EOI from bit 1. With special nesting on, the in-service bit of the cascade line (line 2) is left out of the service level, so that line can interrupt again while it is in service.
- R11: A set bit of `req_i` at a clock edge sets the matching pending bit. Pending bits are cleared only by acknowledge, poll read, initialisation or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 8 | Request-set pulses from the capture block |
| ack_i | input | 1 | Interrupt acknowledge strobe from the processor |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (has effect only in poll) |
| addr | input | 1 | Port select: 0 commands, 1 data/mask |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from current state |
| irq_o | output | 1 | Interrupt request to the processor |
| line_o | output | 3 | Winning line index (0 when `irq_o` is low) |
| vector_o | output | 8 | Vector base plus winning line |

## Verification
Every state change lands on the clock edge that samples the stimulus. Because priority resolution is purely combinational, `irq_o`, `line_o`, `vector_o` and `rdata` show the new state in the very next cycle, with no added latency. The bench drives each write, acknowledge or request pulse on a falling edge and removes it on the following falling edge. It checks the outputs at that second falling edge, one full edge after the update. Read data is sampled one nanosecond after `rd_en` rises, before the edge that carries out a poll's side effect, so each poll result and the disarm that follows are observed separately.

// File: rtl/prio_intc_pkg.sv
`timescale 1ns/1ps
// Shared types for the interrupt controller: decoded bus operations and
// the initialisation word sequencer states.
package prio_intc_pkg;

    localparam int BUS_W = 8;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_INIT,
        OP_READCTL,
        OP_AEOIROT,
        OP_EOI_NS,
        OP_EOI_SP,
        OP_SETPRI,
        OP_DATA
    } op_e;

    typedef struct packed {
        op_e              op;
        logic             rot;
        logic [BUS_W-1:0] val;
    } cmd_t;

    typedef enum logic [1:0] {
        SEQ_RUN,
        SEQ_BASE,
        SEQ_SKIP,
        SEQ_MODE
    } seq_e;

endpackage

// File: rtl/prio_intc_resolver.sv
`timescale 1ns/1ps
// Rotated priority encoder. Takes a set of lines and a priority origin and
// returns the best priority (N_LINES when the set is empty) and its line.
// Assumes N_LINES is a power of two, so the index wraps by truncation.
module prio_intc_resolver #(
    parameter  int N_LINES = 8,
    localparam int IW      = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] set_i,
    input  logic [IW-1:0]      offset_i,
    output logic [IW:0]        prio_o,
    output logic [IW-1:0]      line_o
);

    // Scan priorities from weakest to strongest so the strongest wins last.
    always_comb begin
        prio_o = (IW+1)'(N_LINES);
        line_o = '0;
        for (int p = N_LINES - 1; p >= 0; p--) begin
            if (set_i[IW'(p) + offset_i]) begin
                prio_o = (IW+1)'(p);
                line_o = IW'(p) + offset_i;
            end
        end
    end

endmodule

// File: rtl/prio_intc_decode.sv
`timescale 1ns/1ps
// Bus write decoder. Classifies a write into one controller operation.
// Assumes at most one write per cycle; the bit positions are fixed by the
// command set and do not scale with the line count.
module prio_intc_decode
    import prio_intc_pkg::*;
(
    input  logic             wr_en,
    input  logic             addr,
    input  logic [BUS_W-1:0] wdata,
    output cmd_t             cmd_o
);

    // Map port and data bits to an operation code plus its rotate flag.
    always_comb begin
        cmd_o.op  = OP_NONE;
        cmd_o.rot = 1'b0;
        cmd_o.val = wdata;
        if (wr_en) begin
            if (addr) begin
                cmd_o.op = OP_DATA;
            end else if (wdata[4]) begin
                cmd_o.op = OP_INIT;
            end else if (wdata[3]) begin
                cmd_o.op = OP_READCTL;
            end else begin
                case (wdata[7:5])
                    3'd0, 3'd4: cmd_o.op = OP_AEOIROT;
                    3'd1:       cmd_o.op = OP_EOI_NS;
                    3'd5: begin
                        cmd_o.op  = OP_EOI_NS;
                        cmd_o.rot = 1'b1;
                    end
                    3'd3:       cmd_o.op = OP_EOI_SP;
                    3'd7: begin
                        cmd_o.op  = OP_EOI_SP;
                        cmd_o.rot = 1'b1;
                    end
                    3'd6:       cmd_o.op = OP_SETPRI;
                    default:    cmd_o.op = OP_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/prio_intc.sv
`timescale 1ns/1ps
// Programmable prioritised interrupt controller, single device.
// Holds pending, mask and in-service registers, resolves a rotatable
// priority and raises irq_o when the best unmasked request beats the
// service level. Outputs are combinational from the registers, so they
// follow every register update with no extra cycle. Assumes ack_i and bus
// accesses are not issued in the same cycle by a well-behaved host.
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter  int N_LINES      = 8,
    parameter  int CASCADE_LINE = 2,
    localparam int IW           = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req_i,
    input  logic               ack_i,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic               addr,
    input  logic [BUS_W-1:0]   wdata,
    output logic [BUS_W-1:0]   rdata,
    output logic               irq_o,
    output logic [IW-1:0]      line_o,
    output logic [BUS_W-1:0]   vector_o
);

    localparam logic [N_LINES-1:0] CASC_BIT = N_LINES'(1) << CASCADE_LINE;

    logic [N_LINES-1:0] pend_q, pend_n;
    logic [N_LINES-1:0] mask_q, mask_n;
    logic [N_LINES-1:0] isr_q,  isr_n;
    logic [IW-1:0]      offset_q, offset_n;
    logic [BUS_W-1:0]   base_q, base_n;
    logic               readsel_q, readsel_n;
    logic               poll_q, poll_n;
    logic               aeoi_q, aeoi_n;
    logic               rotaeoi_q, rotaeoi_n;
    logic               sfnm_q, sfnm_n;
    logic               need4_q, need4_n;
    seq_e               seq_q, seq_n;

    cmd_t               cmd;
    logic [IW:0]        req_prio, lvl_prio, eoi_prio;
    logic [IW-1:0]      win_line, lvl_line, eoi_line;
    logic [N_LINES-1:0] lvl_set;
    logic               ack_fire, poll_fire;

    prio_intc_decode u_decode (
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .cmd_o (cmd)
    );

    // Best unmasked pending request.
    prio_intc_resolver #(.N_LINES(N_LINES)) u_req_res (
        .set_i    (pend_q & ~mask_q),
        .offset_i (offset_q),
        .prio_o   (req_prio),
        .line_o   (win_line)
    );

    // Service level, with the cascade line hidden in special nesting.
    assign lvl_set = sfnm_q ? (isr_q & ~CASC_BIT) : isr_q;

    prio_intc_resolver #(.N_LINES(N_LINES)) u_lvl_res (
        .set_i    (lvl_set),
        .offset_i (offset_q),
        .prio_o   (lvl_prio),
        .line_o   (lvl_line)
    );

    // Highest in-service line, the target of a general end-of-interrupt.
    prio_intc_resolver #(.N_LINES(N_LINES)) u_eoi_res (
        .set_i    (isr_q),
        .offset_i (offset_q),
        .prio_o   (eoi_prio),
        .line_o   (eoi_line)
    );

    // Raise the interrupt on a strict priority win and present line/vector.
    always_comb begin
        irq_o    = (req_prio < lvl_prio);
        line_o   = irq_o ? win_line : '0;
        vector_o = base_q + BUS_W'(line_o);
    end

    // Readback mux: poll result first, then mask or the selected register.
    always_comb begin
        if (poll_q) begin
            rdata = irq_o ? BUS_W'(win_line) : BUS_W'(N_LINES - 1);
        end else if (addr) begin
            rdata = BUS_W'(mask_q);
        end else if (readsel_q) begin
            rdata = BUS_W'(isr_q);
        end else begin
            rdata = BUS_W'(pend_q);
        end
    end

    assign ack_fire  = ack_i & irq_o;
    assign poll_fire = rd_en & poll_q;

    // Next-state: capture, then acknowledge/poll, then bus writes.
    always_comb begin
        pend_n    = pend_q | req_i;
        mask_n    = mask_q;
        isr_n     = isr_q;
        offset_n  = offset_q;
        base_n    = base_q;
        readsel_n = readsel_q;
        poll_n    = poll_q;
        aeoi_n    = aeoi_q;
        rotaeoi_n = rotaeoi_q;
        sfnm_n    = sfnm_q;
        need4_n   = need4_q;
        seq_n     = seq_q;

        if (ack_fire) begin
            pend_n[win_line] = 1'b0;
            if (aeoi_q) begin
                if (rotaeoi_q) begin
                    offset_n = win_line + IW'(1);
                end
            end else begin
                isr_n[win_line] = 1'b1;
            end
        end

        if (poll_fire) begin
            poll_n = 1'b0;
            if (irq_o) begin
                pend_n[win_line] = 1'b0;
                isr_n[win_line]  = 1'b0;
            end
        end

        case (cmd.op)
            OP_INIT: begin
                pend_n    = '0;
                mask_n    = '0;
                isr_n     = '0;
                offset_n  = '0;
                base_n    = '0;
                readsel_n = 1'b0;
                poll_n    = 1'b0;
                aeoi_n    = 1'b0;
                rotaeoi_n = 1'b0;
                sfnm_n    = 1'b0;
                need4_n   = cmd.val[0];
                seq_n     = SEQ_BASE;
            end
            OP_READCTL: begin
                if (cmd.val[2]) poll_n = 1'b1;
                if (cmd.val[1]) readsel_n = cmd.val[0];
            end
            OP_AEOIROT: rotaeoi_n = cmd.val[7];
            OP_EOI_NS: begin
                if (eoi_prio != (IW+1)'(N_LINES)) begin
                    isr_n[eoi_line] = 1'b0;
                    if (cmd.rot) offset_n = eoi_line + IW'(1);
                end
            end
            OP_EOI_SP: begin
                isr_n[cmd.val[IW-1:0]] = 1'b0;
                if (cmd.rot) offset_n = cmd.val[IW-1:0] + IW'(1);
            end
            OP_SETPRI: offset_n = cmd.val[IW-1:0] + IW'(1);
            OP_DATA: begin
                case (seq_q)
                    SEQ_RUN:  mask_n = cmd.val[N_LINES-1:0];
                    SEQ_BASE: begin
                        base_n = {cmd.val[BUS_W-1:IW], IW'(0)};
                        seq_n  = SEQ_SKIP;
                    end
                    SEQ_SKIP: seq_n = need4_q ? SEQ_MODE : SEQ_RUN;
                    SEQ_MODE: begin
                        sfnm_n = cmd.val[4];
                        aeoi_n = cmd.val[1];
                        seq_n  = SEQ_RUN;
                    end
                    default:  seq_n = SEQ_RUN;
                endcase
            end
            default: ;
        endcase
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= '0;
            mask_q    <= '0;
            isr_q     <= '0;
            offset_q  <= '0;
            base_q    <= '0;
            readsel_q <= 1'b0;
            poll_q    <= 1'b0;
            aeoi_q    <= 1'b0;
            rotaeoi_q <= 1'b0;
            sfnm_q    <= 1'b0;
            need4_q   <= 1'b0;
            seq_q     <= SEQ_RUN;
        end else begin
            pend_q    <= pend_n;
            mask_q    <= mask_n;
            isr_q     <= isr_n;
            offset_q  <= offset_n;
            base_q    <= base_n;
            readsel_q <= readsel_n;
            poll_q    <= poll_n;
            aeoi_q    <= aeoi_n;
            rotaeoi_q <= rotaeoi_n;
            sfnm_q    <= sfnm_n;
            need4_q   <= need4_n;
            seq_q     <= seq_n;
        end
    end

    // lvl_line is only needed for its priority; keep it observable.
    logic lvl_line_unused;
    assign lvl_line_unused = ^lvl_line;

endmodule

// File: rtl/prio_intc_checker.sv
`timescale 1ns/1ps
// Property checker for prio_intc, attached by bind. Watches the ports and
// the pending, mask, in-service, mode and poll registers across cycles.
module prio_intc_checker #(
    parameter  int N_LINES = 8,
    localparam int IW      = $clog2(N_LINES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_o,
    input logic [IW-1:0]      line_o,
    input logic               ack_i,
    input logic               wr_en,
    input logic               rd_en,
    input logic               addr,
    input logic               init_bit,
    input logic [N_LINES-1:0] pend_q,
    input logic [N_LINES-1:0] mask_q,
    input logic [N_LINES-1:0] isr_q,
    input logic               aeoi_q,
    input logic               poll_q
);

    AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_q[line_o] && !mask_q[line_o])); // R1

    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((pend_q & ~mask_q) != '0)); // R2

    AST_INIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && init_bit) |=> !irq_o); // R3

    AST_ACK_MARKS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && !aeoi_q && !wr_en && !rd_en) |=> isr_q[$past(line_o)]); // R7

    AST_AEOI_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && aeoi_q && !wr_en && !rd_en) |=> $stable(isr_q)); // R7

    AST_POLL_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && poll_q && !wr_en) |=> !poll_q); // R8

endmodule

bind prio_intc prio_intc_checker #(.N_LINES(N_LINES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_o    (irq_o),
    .line_o   (line_o),
    .ack_i    (ack_i),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .init_bit (wdata[4]),
    .pend_q   (pend_q),
    .mask_q   (mask_q),
    .isr_q    (isr_q),
    .aeoi_q   (aeoi_q),
    .poll_q   (poll_q)
);

// File: tb/prio_intc_bench.sv
`timescale 1ns/1ps
// Directed bench for prio_intc: one task per scenario, each checking itself.
module prio_intc_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_i = '0;
    logic       ack_i = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_o;
    logic [2:0] line_o;
    logic [7:0] vector_o;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    prio_intc u_prio_intc (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_i(ack_i),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_o(irq_o), .line_o(line_o), .vector_o(vector_o)
    );

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic raise(logic [7:0] m);
        @(negedge clk);
        req_i = m;
        @(negedge clk);
        req_i = '0;
    endtask

    task automatic do_ack();
        @(negedge clk);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R3 irq after reset", irq_o, 0);
        rd(1'b1, v); check("R3 mask after reset", v, 8'h00);
        rd(1'b0, v); check("R3 pending after reset", v, 8'h00);
    endtask

    task automatic t_basic();
        logic [7:0] v;
        wr(1'b0, 8'h10);
        wr(1'b1, 8'h27);
        wr(1'b1, 8'hAA);
        raise(8'h28);
        check("R11 irq after request", irq_o, 1);
        check("R1 winner line", line_o, 3);
        check("R9 vector base+line", vector_o, 8'h23);
        wr(1'b1, 8'h08);
        check("R4 masked winner moves", line_o, 5);
        check("R9 vector after mask", vector_o, 8'h25);
        rd(1'b1, v); check("R4 mask readback", v, 8'h08);
        rd(1'b0, v); check("R5 pending readback", v, 8'h28);
    endtask

    task automatic t_nesting();
        logic [7:0] v;
        do_ack();
        check("R2 only masked left", irq_o, 0);
        wr(1'b0, 8'h0B);
        rd(1'b0, v); check("R7 ack sets isr", v, 8'h20);
        wr(1'b1, 8'h00);
        check("R2 stronger request interrupts", irq_o, 1);
        check("R2 nested line", line_o, 3);
        do_ack();
        raise(8'h80);
        check("R2 weaker request held", irq_o, 0);
        rd(1'b0, v); check("R7 nested isr", v, 8'h28);
    endtask

    task automatic t_eoi();
        logic [7:0] v;
        wr(1'b0, 8'h20);
        rd(1'b0, v); check("R6 general EOI clears best", v, 8'h20);
        check("R2 line 7 still below line 5", irq_o, 0);
        wr(1'b0, 8'h20);
        check("R6 second EOI releases line 7", irq_o, 1);
        check("R6 line after EOI", line_o, 7);
        do_ack();
        wr(1'b0, 8'h63);
        rd(1'b0, v); check("R6 specific EOI other line", v, 8'h80);
        wr(1'b0, 8'h40);
        rd(1'b0, v); check("R6 code 2 no effect", v, 8'h80);
        wr(1'b0, 8'h67);
        rd(1'b0, v); check("R6 specific EOI line 7", v, 8'h00);
    endtask

    task automatic t_rotation();
        wr(1'b0, 8'hC3);
        raise(8'h24);
        check("R1 origin 4 picks line 5", line_o, 5);
        do_ack();
        check("R2 line 2 below in-service 5", irq_o, 0);
        wr(1'b0, 8'hA0);
        raise(8'h20);
        check("R6 rotating EOI origin 6", line_o, 2);
        do_ack();
        check("R2 line 5 below in-service 2", irq_o, 0);
        wr(1'b0, 8'hE2);
        raise(8'h02);
        check("R6 rotating specific EOI origin 3", line_o, 5);
    endtask

    task automatic t_poll();
        logic [7:0] v;
        wr(1'b0, 8'h0C);
        rd(1'b0, v); check("R8 poll returns winner", v, 5);
        check("R8 poll clears request", line_o, 1);
        rd(1'b0, v); check("R8 poll disarmed after one read", v, 8'h00);
        wr(1'b0, 8'h0C);
        rd(1'b1, v); check("R8 poll on port 1", v, 1);
        check("R11 pending empty after polls", irq_o, 0);
        wr(1'b0, 8'h0C);
        rd(1'b0, v); check("R8 empty poll returns 7", v, 7);
    endtask

    task automatic t_autoeoi();
        logic [7:0] v;
        wr(1'b1, 8'hF0);
        raise(8'h08);
        wr(1'b0, 8'h11);
        check("R3 init drops irq", irq_o, 0);
        wr(1'b1, 8'h47);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h02);
        rd(1'b1, v); check("R3 init clears mask", v, 8'h00);
        rd(1'b0, v); check("R3 init clears pending", v, 8'h00);
        wr(1'b0, 8'h80);
        raise(8'h41);
        check("R3 origin reset to 0", line_o, 0);
        check("R9 new base", vector_o, 8'h40);
        do_ack();
        wr(1'b0, 8'h0B);
        rd(1'b0, v); check("R7 auto-EOI leaves isr", v, 8'h00);
        check("R9 vector line 6", vector_o, 8'h46);
        raise(8'h01);
        check("R7 auto rotation origin 1", line_o, 6);
        do_ack();
        check("R7 auto rotation origin 7", line_o, 0);
        wr(1'b0, 8'h00);
        do_ack();
        raise(8'h41);
        check("R6 code 0 stops auto rotation", line_o, 0);
    endtask

    task automatic t_nesting_mode();
        wr(1'b0, 8'h10);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h00);
        raise(8'h04);
        do_ack();
        raise(8'h04);
        check("R2 equal priority not raised", irq_o, 0);
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h08);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h10);
        raise(8'h04);
        do_ack();
        raise(8'h04);
        check("R10 cascade line re-interrupts", irq_o, 1);
        check("R10 cascade line index", line_o, 2);
        check("R10 vector", vector_o, 8'h0A);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_basic();
                t_nesting();
                t_eoi();
                t_rotation();
                t_poll();
                t_autoeoi();
                t_nesting_mode();
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule